// File: doc/BRIEF.md
# Early receive status tracker

This block follows each incoming frame on an Ethernet receive path and keeps a byte-wide status register that software reads and clears by writing ones. A byte strobe advances a per-frame counter. Once that count passes a programmable threshold, the block raises an early-OK flag and asks for a receive-OK interrupt. Software can then start draining the frame before it has finished arriving.

When the frame ends, the early-OK flag is retired. In the same cycle, the block pulses either receive-OK or receive-error towards the main interrupt-status logic and records whether the frame was good or bad. An overwrite flag watches the receive ring. It is raised when the local write pointer meets the software read pointer, as happens when the write side rewinds to refill an errored frame. This is tracked separately from buffer overflow.

Top module: `rx_early_status`

## Requirements
- R1: While `rst_n` is low and after its release, `status` reads 0x00 and `rok_irq_req`, `isr_rok_set` and `isr_rer_set` are low until an event occurs.
- R2: The status layout is fixed: bits 7..4 always read 0, bit 3 = good-frame flag, bit 2 = bad-frame flag, bit 1 = overwrite flag, bit 0 = early-OK flag.
- R3: The byte count restarts on `sof` (a `byte_vld` in the `sof` cycle counts as the first byte). It advances only while a frame is in progress and saturates at 2^CNT_W-1 instead of wrapping.
- R4: The early-OK flag is raised one edge after a cycle in which the registered byte count is strictly greater than `thresh`. It is raised at most once per frame and not in a cycle that carries `sof` or `eof`.
- R5: `rok_irq_req` is a one-cycle pulse high exactly in the first cycle that the early-OK flag reads 1.
- R6: An `eof` during a frame gives, one edge later, a single-cycle `isr_rok_set` (if `eof_good`=1) or `isr_rer_set` (if 0). In that same cycle the early-OK flag reads 0 and the good-frame or bad-frame flag reads 1.
- R7: An `eof` while no frame is in progress has no effect on `status` or on any pulse output.
- R8: The overwrite flag is set one edge after any cycle in which `wr_ptr` equals `rd_ptr`.
- R9: A cycle with `reg_wr_en`=1 clears each of bits 3..0 whose `reg_wr_data` bit is 1. Zero bits and bits 7..4 of the written data have no effect.
- R10: When a hardware set and a software write-1 clear hit the same flag in the same cycle, the flag reads 1 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_vld | input | 1 | One received byte this cycle |
| sof | input | 1 | Start-of-frame pulse |
| eof | input | 1 | End-of-frame pulse |
| eof_good | input | 1 | Frame quality, sampled with `eof` (1 = good) |
| thresh | input | CNT_W | Early-receive byte threshold |
| wr_ptr | input | PTR_W | Local receive ring write pointer |
| rd_ptr | input | PTR_W | Software receive ring read pointer |
| reg_wr_en | input | 1 | Software write strobe to the status register |
| reg_wr_data | input | 8 | Write-1-to-clear data |
| status | output | 8 | Status register read value |
| rok_irq_req | output | 1 | Receive-OK interrupt request pulse |
| isr_rok_set | output | 1 | Pulse setting receive-OK in the interrupt status |
| isr_rer_set | output | 1 | Pulse setting receive-error in the interrupt status |

## Verification
The bench builds the block with CNT_W=4 and PTR_W=6. A 4-bit counter reaches its ceiling of 15 within a short frame, and the threshold can be driven to its maximum value. Lowering the threshold mid-frame after the counter has saturated then shows the difference between saturating and wrapping. The small pointer width lets the bench make the ring pointers meet, or keep them apart, directly.

// File: rtl/rx_es_pkg.sv
package rx_es_pkg;
  localparam int unsigned REG_W     = 8;
  localparam int unsigned FLAG_N    = 4;
  localparam int unsigned BIT_EARLY = 0;
  localparam int unsigned BIT_OVW   = 1;
  localparam int unsigned BIT_BAD   = 2;
  localparam int unsigned BIT_GOOD  = 3;
endpackage

// File: rtl/rx_es_frame_track.sv
module rx_es_frame_track #(
  parameter int unsigned CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             byte_vld_i,
  input  logic             sof_i,
  input  logic             eof_i,
  input  logic [CNT_W-1:0] thresh_i,
  output logic             active_o,
  output logic             early_set_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             act_q, act_d;
  logic             fired_q, fired_d;
  logic             early_set;

  // early trigger uses the registered count
  always_comb begin
    early_set = act_q & ~fired_q & ~eof_i & ~sof_i & (cnt_q > thresh_i);
  end

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (sof_i) begin
      cnt_en = 1'b1;
      cnt_d  = byte_vld_i ? CNT_ONE : '0;
    end else if (act_q && byte_vld_i && (cnt_q != CNT_MAX)) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + CNT_ONE;
    end
  end

  always_comb begin
    act_d   = act_q;
    fired_d = fired_q;
    if (sof_i) begin
      act_d   = 1'b1;
      fired_d = 1'b0;
    end else begin
      if (eof_i)     act_d   = 1'b0;
      if (early_set) fired_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      act_q   <= 1'b0;
      fired_q <= 1'b0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      act_q   <= act_d;
      fired_q <= fired_d;
    end
  end

  assign active_o    = act_q;
  assign early_set_o = early_set;

  // R3: the counter holds at its ceiling
  a_r3_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_MAX && !sof_i) |=> (cnt_q == CNT_MAX));

  // R4: a trigger marks the frame as fired
  a_r4_once_per_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (early_set && !sof_i) |=> (fired_q && !early_set));
endmodule

// File: rtl/rx_es_flag_bank.sv
module rx_es_flag_bank #(
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] hw_clr_i,
  input  logic [N-1:0] sw_clr_i,
  output logic [N-1:0] flags_o
);
  logic [N-1:0] q;

  for (genvar g = 0; g < N; g++) begin : g_bit
    logic upd, nxt;

    always_comb begin
      upd = set_i[g] | hw_clr_i[g] | sw_clr_i[g];
      nxt = set_i[g] | (q[g] & ~(hw_clr_i[g] | sw_clr_i[g]));
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q[g] <= 1'b0;
      else if (upd) q[g] <= nxt;
    end

    // R10: a set beats a clear in the same cycle
    a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[g] |=> flags_o[g]);

    // R9: a write-1 clear without a set empties the flag
    a_r9_w1c: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_clr_i[g] && !set_i[g]) |=> !flags_o[g]);
  end

  assign flags_o = q;
endmodule

// File: rtl/rx_early_status.sv
module rx_early_status
  import rx_es_pkg::*;
#(
  parameter int unsigned CNT_W = 11,
  parameter int unsigned PTR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             byte_vld,
  input  logic             sof,
  input  logic             eof,
  input  logic             eof_good,
  input  logic [CNT_W-1:0] thresh,
  input  logic [PTR_W-1:0] wr_ptr,
  input  logic [PTR_W-1:0] rd_ptr,
  input  logic             reg_wr_en,
  input  logic [REG_W-1:0] reg_wr_data,
  output logic [REG_W-1:0] status,
  output logic             rok_irq_req,
  output logic             isr_rok_set,
  output logic             isr_rer_set
);
  localparam int unsigned PAD_W = REG_W - FLAG_N;

  logic              active, early_set, frame_end;
  logic [FLAG_N-1:0] set_v, hw_clr_v, sw_clr_v, flags;
  logic              irq_q, rok_q, rer_q;
  logic              irq_d, rok_d, rer_d;
  logic [PAD_W-1:0]  unused_wr_hi;

  assign unused_wr_hi = reg_wr_data[REG_W-1:FLAG_N];

  rx_es_frame_track #(.CNT_W(CNT_W)) u_track (
    .clk         (clk),
    .rst_n       (rst_n),
    .byte_vld_i  (byte_vld),
    .sof_i       (sof),
    .eof_i       (eof),
    .thresh_i    (thresh),
    .active_o    (active),
    .early_set_o (early_set)
  );

  always_comb begin
    frame_end            = eof & active;
    set_v                = '0;
    set_v[BIT_EARLY]     = early_set;
    set_v[BIT_OVW]       = (wr_ptr == rd_ptr);
    set_v[BIT_BAD]       = frame_end & ~eof_good;
    set_v[BIT_GOOD]      = frame_end & eof_good;
    hw_clr_v             = '0;
    hw_clr_v[BIT_EARLY]  = frame_end;
    sw_clr_v             = reg_wr_en ? reg_wr_data[FLAG_N-1:0] : '0;
  end

  rx_es_flag_bank #(.N(FLAG_N)) u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_i    (set_v),
    .hw_clr_i (hw_clr_v),
    .sw_clr_i (sw_clr_v),
    .flags_o  (flags)
  );

  always_comb begin
    irq_d = early_set;
    rok_d = frame_end & eof_good;
    rer_d = frame_end & ~eof_good;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
      rok_q <= 1'b0;
      rer_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
      rok_q <= rok_d;
      rer_q <= rer_d;
    end
  end

  assign status      = {{PAD_W{1'b0}}, flags};
  assign rok_irq_req = irq_q;
  assign isr_rok_set = rok_q;
  assign isr_rer_set = rer_q;

  // R5: the interrupt request coincides with a raised early flag
  a_r5_irq_with_flag: assert property (@(posedge clk) disable iff (!rst_n)
    rok_irq_req |-> status[BIT_EARLY]);

  // R6: frame-end pulses find the early flag retired
  a_r6_early_retired: assert property (@(posedge clk) disable iff (!rst_n)
    (isr_rok_set || isr_rer_set) |-> !status[BIT_EARLY]);

  // R6: only one verdict per frame end
  a_r6_one_verdict: assert property (@(posedge clk) disable iff (!rst_n)
    !(isr_rok_set && isr_rer_set));

  // R8: pointer match raises the overwrite flag
  a_r8_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ptr == rd_ptr) |=> status[BIT_OVW]);
endmodule

// File: tb/rx_early_status_tb.sv
module rx_early_status_tb_top;
  localparam int CW  = 4;
  localparam int PW  = 6;
  localparam int MAX = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          byte_vld = 0, sof = 0, eof = 0, eof_good = 0;
  logic [CW-1:0] thresh = '0;
  logic [PW-1:0] wr_ptr = 6'd1, rd_ptr = 6'd9;
  logic          reg_wr_en = 0;
  logic [7:0]    reg_wr_data = '0;
  logic [7:0]    status;
  logic          rok_irq_req, isr_rok_set, isr_rer_set;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rx_early_status #(.CNT_W(CW), .PTR_W(PW)) dut_i (
    .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .sof(sof), .eof(eof),
    .eof_good(eof_good), .thresh(thresh), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
    .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data), .status(status),
    .rok_irq_req(rok_irq_req), .isr_rok_set(isr_rok_set), .isr_rer_set(isr_rer_set)
  );

  // behavioural reference
  int       m_cnt;
  bit       m_act, m_fir, m_irq, m_rok, m_rer;
  bit [3:0] m_stat;

  always @(posedge clk or negedge rst_n) begin : model
    bit es, ev;
    bit [3:0] ns;
    if (!rst_n) begin
      m_cnt <= 0; m_act <= 0; m_fir <= 0; m_irq <= 0;
      m_rok <= 0; m_rer <= 0; m_stat <= 0;
    end else begin
      es = m_act && !m_fir && !eof && !sof && (m_cnt > int'(thresh));
      ev = eof && m_act;
      m_irq <= es;
      m_rok <= ev && eof_good;
      m_rer <= ev && !eof_good;
      ns = m_stat & ~(reg_wr_en ? reg_wr_data[3:0] : 4'h0);
      if (ev) ns[0] = 1'b0;
      if (ev && eof_good) ns[3] = 1'b1;
      if (ev && !eof_good) ns[2] = 1'b1;
      if (wr_ptr == rd_ptr) ns[1] = 1'b1;
      if (es) ns[0] = 1'b1;
      m_stat <= ns;
      if (sof) begin
        m_cnt <= byte_vld ? 1 : 0; m_act <= 1; m_fir <= 0;
      end else begin
        if (m_act && byte_vld && m_cnt < MAX) m_cnt <= m_cnt + 1;
        if (eof) m_act <= 0;
        if (es) m_fir <= 1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // per-cycle comparison against the reference (R2 R4 R5 R6 R8)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(status == {4'h0, m_stat}, "R2 status vs model", status, {4'h0, m_stat});
      check(rok_irq_req == m_irq, "R5 irq vs model", rok_irq_req, m_irq);
      check(isr_rok_set == m_rok, "R6 rok vs model", isr_rok_set, m_rok);
      check(isr_rer_set == m_rer, "R6 rer vs model", isr_rer_set, m_rer);
    end
  end

  task automatic tick();
    @(posedge clk); #1;
    byte_vld = 0; sof = 0; eof = 0; reg_wr_en = 0; reg_wr_data = '0;
  endtask

  task automatic bytes(input int n);
    for (int i = 0; i < n; i++) begin byte_vld = 1; tick(); end
  endtask

  task automatic w1c(input logic [7:0] d);
    reg_wr_en = 1; reg_wr_data = d; tick();
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(5 * 20000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    thresh = 4'd5;
    #12;
    check(status == 8'h00, "R1 status in reset", status, 0);
    check({rok_irq_req, isr_rok_set, isr_rer_set} == 3'b000, "R1 pulses in reset",
          {rok_irq_req, isr_rok_set, isr_rer_set}, 0);
    @(negedge clk); rst_n = 1;
    tick(); tick();
    check(status == 8'h00, "R1 status after release", status, 0);

    // good frame with early trigger
    sof = 1; byte_vld = 1; tick();           // count 1
    bytes(4);                                // count 5
    tick();
    check(status[0] == 1'b0, "R4 count equal to threshold", status[0], 0);
    bytes(1);                                // count 6
    tick();
    check(status[0] == 1'b1, "R4 early flag above threshold", status[0], 1);
    check(rok_irq_req == 1'b1, "R5 irq with flag", rok_irq_req, 1);
    tick();
    check(rok_irq_req == 1'b0, "R5 irq single cycle", rok_irq_req, 0);
    bytes(3); tick();
    check(rok_irq_req == 1'b0, "R4 no second trigger", rok_irq_req, 0);
    eof = 1; eof_good = 1; tick();
    check(isr_rok_set == 1'b1 && isr_rer_set == 1'b0, "R6 good verdict",
          {isr_rok_set, isr_rer_set}, 2'b10);
    check(status == 8'h08, "R6 early retired, good set", status, 8'h08);

    // software clears
    w1c(8'h00);
    check(status == 8'h08, "R9 zero write no effect", status, 8'h08);
    w1c(8'hF0);
    check(status == 8'h08, "R9 upper bits ignored", status, 8'h08);
    w1c(8'h08);
    check(status == 8'h00, "R9 write-1 clears", status, 0);

    // bad frame below threshold
    sof = 1; tick(); bytes(2);
    eof = 1; eof_good = 0; tick();
    check(isr_rer_set == 1'b1 && isr_rok_set == 1'b0, "R6 bad verdict",
          {isr_rok_set, isr_rer_set}, 2'b01);
    check(status == 8'h04, "R6 bad flag", status, 8'h04);
    w1c(8'h04);

    // stray end of frame
    eof = 1; eof_good = 1; tick();
    check({isr_rok_set, isr_rer_set} == 2'b00, "R7 stray eof no pulse",
          {isr_rok_set, isr_rer_set}, 0);
    check(status == 8'h00, "R7 stray eof no flag", status, 0);

    // overwrite flag
    wr_ptr = 6'd9; tick();
    check(status[1] == 1'b1, "R8 pointers meet", status[1], 1);
    reg_wr_en = 1; reg_wr_data = 8'h02; tick();
    check(status[1] == 1'b1, "R10 set beats clear", status[1], 1);
    wr_ptr = 6'd10; w1c(8'h02);
    check(status[1] == 1'b0, "R8 cleared once apart", status[1], 0);

    // saturation: count stays at ceiling, threshold lowered afterwards
    thresh = 4'd15;
    sof = 1; byte_vld = 1; tick(); bytes(19); tick();
    check(status[0] == 1'b0, "R3 saturated count not above max threshold", status[0], 0);
    thresh = 4'd14; tick(); tick();
    check(status[0] == 1'b1, "R3 saturated count holds at ceiling", status[0], 1);
    eof = 1; eof_good = 1; tick();
    check(status == 8'h08, "R6 saturated frame end", status, 8'h08);
    w1c(8'h0F);
    check(status == 8'h00, "R9 clear all", status, 0);
    tick(); tick();
    finish_run();
  end
endmodule